// File: doc/BRIEF.md
# ADC Sample Word Formatter

This block sits on the receive side of a dual-channel converter that delivers 13-bit samples. Each beat carries one raw word per channel. A coding flag tells the block whether those words are offset binary or two's complement. A mode select picks one of four output forms: the full 13-bit word, a 12-bit word with the least significant bit dropped, or a 12-bit reduced-range word taken from the low twelve bits. In the reduced-range form the top two raw bits decide whether the value has wrapped, and a wrapped value is saturated. The fourth mode code is an alias of the full form.

Whatever the input coding, every channel leaves the block as a two's-complement word sign-extended to 13 bits, together with an overrange flag and an underrange flag. The mode and the coding flag travel with the beat.

Both sides of the block are valid/ready streams. A beat moves on any clock edge where valid and ready are both high. A single register stage sits between the two sides. The input side is ready whenever that stage is empty or is being drained in the same cycle. While the output is stalled, the held beat does not change.

Top module: `adc_word_formatter`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, out_valid is low and in_ready is high.
- R2: in_ready equals (not out_valid) or out_ready. An accepted beat appears on the output on the next clock edge. While out_valid is high and out_ready is low, out_valid, out_data and both flag vectors hold their values.
- R3: When in_twos is 0, the raw word is offset binary and the block inverts its bit 12 to form a two's-complement value v. When in_twos is 1, the raw word is used as v unchanged. Raw offset-binary 0x1000 (midscale) therefore becomes 0.
- R4: With mode 0, channel output is v itself. Overrange is set exactly when v is 0x0FFF, and underrange exactly when v is 0x1000.
- R5: With mode 1, channel output is v shifted right by one with the sign kept, placed in 13 bits. The flags follow the R4 rule, so the dropped LSB must agree with the other bits: v = 0x0FFE gives 0x07FF with no flag.
- R6: With mode 2, when bits 12 and 11 of v are equal, the output is v[11:0] sign-extended to 13 bits and both flags are low.
- R7: With mode 2, v[12]=0 with v[11]=1 sets overrange and clamps the output to 0x07FF. v[12]=1 with v[11]=0 sets underrange and clamps the output to 0x1800, which is 0x800 sign-extended.
- R8: Mode 3 behaves exactly like mode 0.
- R9: On a valid output, a channel's overrange and underrange flags are never both high. Overrange implies a non-negative word, and underrange implies a negative word.
- R10: Each channel is formatted from its own raw word only. The channels share the mode and coding flag of the beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Block can accept a beat |
| in_raw | input | NCH*SW (26) | Raw words, channel c at bits [c*SW +: SW] |
| in_twos | input | 1 | Raw coding: 0 offset binary, 1 two's complement |
| in_mode | input | 2 | 0 full, 1 LSB dropped, 2 reduced range, 3 same as 0 |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream accepts the beat |
| out_data | output | NCH*SW (26) | Formatted words, same channel packing as in_raw |
| out_over | output | NCH (2) | Overrange flag per channel |
| out_under | output | NCH (2) | Underrange flag per channel |

## Verification
The bench aims at the codes where the rules are most easily confused. One case is the difference between a raw word of all ones in the two codings: a design that flags raw bits rather than the converted value reports a false overrange for -1. Another is the 12-bit word whose top twelve bits are saturated but whose LSB disagrees, which a design that looks only at twelve bits wrongly flags. The remaining cases are the two wrap-around bands of the reduced mode, where a missing clamp passes through a wrapped value of the wrong sign, and a stalled output that must hold its beat while new input is refused.

// File: rtl/adcfmt_pkg.sv
package adcfmt_pkg;
  typedef enum logic [1:0] {
    FMT_FULL    = 2'd0,
    FMT_TRUNC   = 2'd1,
    FMT_REDUCED = 2'd2,
    FMT_ALIAS   = 2'd3
  } fmt_mode_e;
endpackage

// File: rtl/adcfmt_lane.sv
module adcfmt_lane
  import adcfmt_pkg::*;
#(
  parameter int SW = 13
) (
  input  logic [SW-1:0] raw,
  input  logic          twos,
  input  fmt_mode_e     mode,
  output logic [SW-1:0] word,
  output logic          over,
  output logic          under
);
  localparam logic [SW-1:0] FULL_TOP = {1'b0, {(SW-1){1'b1}}};
  localparam logic [SW-1:0] FULL_BOT = {1'b1, {(SW-1){1'b0}}};
  localparam logic [SW-2:0] RED_TOP  = {1'b0, {(SW-2){1'b1}}};
  localparam logic [SW-2:0] RED_BOT  = {1'b1, {(SW-2){1'b0}}};

  logic [SW-1:0] tc;
  logic [SW-2:0] red;
  logic          hit_top, hit_bot, wrap_hi, wrap_lo;

  // offset binary differs from two's complement only in the sign bit
  assign tc      = {raw[SW-1] ^ ~twos, raw[SW-2:0]};
  assign hit_top = (tc == FULL_TOP);
  assign hit_bot = (tc == FULL_BOT);
  assign wrap_hi = ~tc[SW-1] &  tc[SW-2];
  assign wrap_lo =  tc[SW-1] & ~tc[SW-2];

  always_comb begin
    red = tc[SW-2:0];
    if (wrap_hi)      red = RED_TOP;
    else if (wrap_lo) red = RED_BOT;
  end

  always_comb begin
    unique case (mode)
      FMT_TRUNC: begin
        word  = {tc[SW-1], tc[SW-1:1]};
        over  = hit_top;
        under = hit_bot;
      end
      FMT_REDUCED: begin
        word  = {red[SW-2], red};
        over  = wrap_hi;
        under = wrap_lo;
      end
      default: begin
        word  = tc;
        over  = hit_top;
        under = hit_bot;
      end
    endcase
  end
endmodule

// File: rtl/adcfmt_stage.sv
module adcfmt_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  assign in_ready = ~out_valid | out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_data <= '0;
    end else if (in_ready && in_valid) begin
      out_data <= in_data;
    end
  end
endmodule

// File: rtl/adc_word_formatter.sv
module adc_word_formatter
  import adcfmt_pkg::*;
#(
  parameter int NCH = 2,
  parameter int SW  = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [NCH*SW-1:0] in_raw,
  input  logic              in_twos,
  input  logic [1:0]        in_mode,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [NCH*SW-1:0] out_data,
  output logic [NCH-1:0]    out_over,
  output logic [NCH-1:0]    out_under
);
  localparam int LW = SW + 2;
  localparam int BW = NCH * LW;

  logic [BW-1:0] fmt_bus, reg_bus;
  fmt_mode_e     mode_e;

  assign mode_e = fmt_mode_e'(in_mode);

  for (genvar c = 0; c < NCH; c++) begin : g_lane
    logic [SW-1:0] w;
    logic          ov, un;

    adcfmt_lane #(.SW(SW)) u_lane (
      .raw  (in_raw[c*SW +: SW]),
      .twos (in_twos),
      .mode (mode_e),
      .word (w),
      .over (ov),
      .under(un)
    );

    assign fmt_bus[c*LW +: LW] = {un, ov, w};
    assign out_data[c*SW +: SW] = reg_bus[c*LW +: SW];
    assign out_over[c]          = reg_bus[c*LW + SW];
    assign out_under[c]         = reg_bus[c*LW + SW + 1];
  end

  adcfmt_stage #(.W(BW)) u_stage (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_data  (fmt_bus),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_data (reg_bus)
  );
endmodule

// File: rtl/adcfmt_checker.sv
module adcfmt_checker #(
  parameter int NCH = 2,
  parameter int SW  = 13
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [NCH*SW-1:0] out_data,
  input logic [NCH-1:0]    out_over,
  input logic [NCH-1:0]    out_under
);
  p_reset_idle_r1: assert property (@(posedge clk) !rst_n |=> !out_valid);

  p_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data)
      && $stable(out_over) && $stable(out_under));

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    p_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !(out_over[c] && out_under[c]));

    p_over_sign_r9: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_over[c] |-> !out_data[c*SW + SW - 1]);

    p_under_sign_r7: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_under[c] |-> out_data[c*SW + SW - 1]);
  end
endmodule

bind adc_word_formatter adcfmt_checker #(.NCH(NCH), .SW(SW)) u_adcfmt_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_data (out_data),
  .out_over (out_over),
  .out_under(out_under)
);

// File: tb/test_adc_word_formatter.sv
module test_adc_word_formatter;
  localparam int CLK_PERIOD = 10;
  localparam int NCH = 2;
  localparam int SW  = 13;

  typedef struct {
    logic [12:0] d [2];
    logic        ov [2];
    logic        un [2];
    string       tag;
  } beat_t;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              in_valid;
  logic              in_ready;
  logic [NCH*SW-1:0] in_raw;
  logic              in_twos;
  logic [1:0]        in_mode;
  logic              out_valid;
  logic              out_ready;
  logic [NCH*SW-1:0] out_data;
  logic [NCH-1:0]    out_over;
  logic [NCH-1:0]    out_under;

  int    errors = 0;
  int    checks = 0;
  beat_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_word_formatter #(.NCH(NCH), .SW(SW)) i_adc_word_formatter (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_raw(in_raw), .in_twos(in_twos), .in_mode(in_mode),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_over(out_over), .out_under(out_under)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // behavioural reference, integer arithmetic on the signed value
  task automatic ref_fmt(input logic [12:0] raw, input logic twos, input logic [1:0] mode,
                         output logic [12:0] d, output logic ov, output logic un);
    int v, r;
    v = twos ? (raw[12] ? int'(raw) - 8192 : int'(raw)) : int'(raw) - 4096;
    ov = 1'b0; un = 1'b0; r = v;
    if (mode == 2'd2) begin
      if (v >= 2048)       begin ov = 1'b1; r = 2047;  end
      else if (v < -2048)  begin un = 1'b1; r = -2048; end
    end else begin
      ov = (v == 4095);
      un = (v == -4096);
      if (mode == 2'd1) r = v >>> 1;
    end
    d = 13'(r);
  endtask

  function automatic string mode_tag(input logic [1:0] m);
    case (m)
      2'd0: return "R4";
      2'd1: return "R5";
      2'd2: return "R6/R7";
      default: return "R8";
    endcase
  endfunction

  // called at a falling edge: compare, drive next inputs, advance the model
  task automatic step(input logic [12:0] r0, input logic [12:0] r1, input logic twos,
                      input logic [1:0] mode, input logic vld, input logic rdy, input string tag);
    beat_t b;
    bit    exp_rdy;
    check(out_valid == (q.size() > 0), "R2 out_valid", out_valid, q.size() > 0);
    if (q.size() > 0 && out_valid) begin
      for (int c = 0; c < NCH; c++) begin
        check(out_data[c*SW +: SW] == q[0].d[c] && out_over[c] == q[0].ov[c]
              && out_under[c] == q[0].un[c],
              $sformatf("%s R10 ch%0d", q[0].tag, c),
              {out_under[c], out_over[c], out_data[c*SW +: SW]},
              {q[0].un[c], q[0].ov[c], q[0].d[c]});
      end
    end
    in_raw    = {r1, r0};
    in_twos   = twos;
    in_mode   = mode;
    in_valid  = vld;
    out_ready = rdy;
    #1;
    exp_rdy = (q.size() == 0) || rdy;
    check(in_ready == exp_rdy, "R2 in_ready", in_ready, exp_rdy);
    if (q.size() > 0 && rdy) void'(q.pop_front());
    if (vld && exp_rdy) begin
      ref_fmt(r0, twos, mode, b.d[0], b.ov[0], b.un[0]);
      ref_fmt(r1, twos, mode, b.d[1], b.ov[1], b.un[1]);
      b.tag = tag;
      q.push_back(b);
    end
    @(negedge clk);
  endtask

  function automatic logic [12:0] pick_raw();
    logic [12:0] hot [8] = '{13'h0000, 13'h1FFF, 13'h0FFF, 13'h1000,
                             13'h0800, 13'h17FF, 13'h07FF, 13'h1800};
    if ($urandom_range(1, 0) == 1) return hot[$urandom_range(7, 0)];
    return 13'($urandom);
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_raw = '0; in_twos = 1'b0;
    in_mode = 2'd0; out_ready = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(out_valid == 1'b0, "R1 out_valid in reset", out_valid, 0);
    check(in_ready == 1'b1, "R1 in_ready in reset", in_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R1 out_valid after reset", out_valid, 0);

    // directed corners, always draining
    step(13'h1000, 13'h1FFF, 1'b0, 2'd0, 1'b1, 1'b1, "R3 midscale/top");
    step(13'h0000, 13'h0FFF, 1'b0, 2'd0, 1'b1, 1'b1, "R4 bottom");
    step(13'h1FFF, 13'h0FFF, 1'b1, 2'd0, 1'b1, 1'b1, "R3 twos -1 / R4 top");
    step(13'h1000, 13'h0000, 1'b1, 2'd0, 1'b1, 1'b1, "R4 twos bottom/zero");
    step(13'h1FFE, 13'h1FFF, 1'b0, 2'd1, 1'b1, 1'b1, "R5 lsb disagrees / top");
    step(13'h0001, 13'h0000, 1'b0, 2'd1, 1'b1, 1'b1, "R5 low edge");
    step(13'h0800, 13'h1000, 1'b1, 2'd2, 1'b1, 1'b1, "R7 twos wraps");
    step(13'h07FF, 13'h1800, 1'b1, 2'd2, 1'b1, 1'b1, "R6 twos in range");
    step(13'h1800, 13'h0700, 1'b0, 2'd2, 1'b1, 1'b1, "R7 offset wraps");
    step(13'h17FF, 13'h0800, 1'b0, 2'd2, 1'b1, 1'b1, "R6 offset in range");
    step(13'h1FFF, 13'h0000, 1'b0, 2'd3, 1'b1, 1'b1, "R8 alias");
    step(13'h0123, 13'h1ABC, 1'b1, 2'd3, 1'b1, 1'b1, "R8 alias mid");

    // stall: beat must be held while out_ready is low, R2
    step(13'h1FFF, 13'h0000, 1'b0, 2'd0, 1'b1, 1'b0, "R2 stall load");
    step(13'h0000, 13'h1FFF, 1'b0, 2'd0, 1'b1, 1'b0, "R2 refused");
    step(13'h0000, 13'h1FFF, 1'b0, 2'd0, 1'b1, 1'b0, "R2 refused");
    step(13'h0555, 13'h0AAA, 1'b0, 2'd2, 1'b1, 1'b1, "R2 resume");

    // random traffic with back-pressure
    for (int i = 0; i < 3000; i++) begin
      logic [1:0] m;
      m = 2'($urandom_range(3, 0));
      step(pick_raw(), pick_raw(), 1'($urandom), m,
           1'($urandom_range(3, 0) != 0), 1'($urandom_range(3, 0) != 0), mode_tag(m));
    end

    for (int i = 0; i < 4; i++) step('0, '0, 1'b0, 2'd0, 1'b0, 1'b1, "drain");
    check(q.size() == 0 && !out_valid, "R2 drained", out_valid, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule